// File: doc/BRIEF.md
# Programmable LED Blink Generator

This block drives one LED pin with a repeating on/off pattern. A power-of-two prescaler derives a step tick from the clock. A period counter then advances once per tick. The output is high for the first part of each period and low for the rest, so the register values set both the blink rate and the duty ratio.

An optional autostop mode counts finished periods. After a programmed number of them, the block switches itself off, drives the LED low and latches a done flag. That flag drives an interrupt line, which software can mask.

Software controls the block through four 16-bit word registers on a simple write-strobe bus. Reads are combinational and use the same address lines. The registers are the time-base/control word, the period, the on-time and the autostop count.

Top module: `blink_gen`

## Requirements
- R1: After reset `led_o` and `irq_o` are 0 and all four registers read 0.
- R2: Byte offset 0x0 is the control word. Bits [3:0] select the divider n, bit 4 is enable, bit 5 is autostop and bit 6 is interrupt mask. Bit 7 is the done flag: it is read-only, and writes to it are ignored. Offset 0x4 is the period (12 bits). Offset 0x8 is the on-time (12 bits). Offset 0xC is the autostop count (16 bits). Bits above each width read 0. Writes take effect only when `addr_i[1:0]` is 0.
- R3: The counter advances once every 2^n clock cycles. These cycles are counted from the last register write. Values of n above 13 behave as 13.
- R4: The counter runs from 0 to period-1 and then wraps to 0. A period of 0 behaves as 1. While the block is enabled, `led_o` is high exactly when the counter is below the on-time.
- R5: An on-time of 0 keeps `led_o` low. An on-time at or above the period keeps `led_o` high for as long as the block is enabled.
- R6: With autostop set, the block stops after N complete periods, where N is the autostop count and a count of 0 behaves as 1. When it stops, it clears the enable bit, drives `led_o` low and sets the done flag.
- R7: `irq_o` equals done AND NOT mask. The done flag stays set until a control-word write clears it.
- R8: The counter restarts at 0 and the remaining-period count is reloaded when software does any of the following: writes the period register, writes the autostop register, or sets enable while enable is 0. `led_o` shows counter value 0 in the cycle after that write.
- R9: A control-word write can land in the same cycle as an autostop stop. In that case the written enable value is kept and the done flag is still set.
- R10: While enable is 0, `led_o` is low and the counter is held at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` (combinational) |
| led_o | output | 1 | Blink output |
| irq_o | output | 1 | Autostop interrupt, after masking |

## Verification
The autostop stop event and a software write to the control word can fall in the same clock cycle. Each one changes the enable bit and the done flag. The bench provokes this at divider 0, because there the stop cycle is fixed: it is the twelfth cycle after enabling with period 4 and a count of 3. It writes the control word, with enable set and autostop cleared, in exactly that cycle. It then judges the result at the ports. The interrupt must be raised, the control word must read back with enable and done both set, and the LED must keep blinking at its normal duty.

// File: rtl/blink_pkg.sv
package blink_pkg;
    // Control word bit positions (software decodes these)
    localparam int TB_EN_BIT   = 4;
    localparam int TB_AUTO_BIT = 5;
    localparam int TB_MASK_BIT = 6;
    localparam int TB_DONE_BIT = 7;

    // Word slot selected by address bits [3:2]
    typedef enum logic [1:0] {
        SLOT_TBASE   = 2'd0,
        SLOT_PERIOD  = 2'd1,
        SLOT_ONTIME  = 2'd2,
        SLOT_STOPCNT = 2'd3
    } slot_e;
endpackage

// File: rtl/blink_regs.sv
module blink_regs
    import blink_pkg::*;
#(
    parameter int SEL_W  = 4,
    parameter int PRD_W  = 12,
    parameter int AS_W   = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              stop_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [SEL_W-1:0]  sel_o,
    output logic              en_o,
    output logic              auto_o,
    output logic              mask_o,
    output logic              done_o,
    output logic [PRD_W-1:0]  period_o,
    output logic [PRD_W-1:0]  ontime_o,
    output logic              restart_o,
    output logic [AS_W-1:0]   reload_o,
    output logic              wr_any_o
);
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             auto_en;
        logic             mask;
        logic             done;
        logic [PRD_W-1:0] period;
        logic [PRD_W-1:0] ontime;
        logic [AS_W-1:0]  stop_cnt;
    } regs_t;

    regs_t q, d;
    slot_e slot;
    logic  aligned, hit_tb, hit_prd, hit_on, hit_as;

    always_comb begin
        slot     = slot_e'(addr_i[3:2]);
        aligned  = (addr_i[1:0] == 2'b00);
        hit_tb   = wr_en_i && aligned && (slot == SLOT_TBASE);
        hit_prd  = wr_en_i && aligned && (slot == SLOT_PERIOD);
        hit_on   = wr_en_i && aligned && (slot == SLOT_ONTIME);
        hit_as   = wr_en_i && aligned && (slot == SLOT_STOPCNT);

        d = q;
        if (hit_tb) begin
            d.sel     = wdata_i[SEL_W-1:0];
            d.en      = wdata_i[TB_EN_BIT];
            d.auto_en = wdata_i[TB_AUTO_BIT];
            d.mask    = wdata_i[TB_MASK_BIT];
            d.done    = 1'b0;
        end
        if (hit_prd) d.period   = wdata_i[PRD_W-1:0];
        if (hit_on)  d.ontime   = wdata_i[PRD_W-1:0];
        if (hit_as)  d.stop_cnt = wdata_i[AS_W-1:0];
        // Stop event: flag always latched, enable dropped unless software rewrites it
        if (stop_i) begin
            d.done = 1'b1;
            if (!hit_tb) d.en = 1'b0;
        end

        restart_o = hit_prd || hit_as || (hit_tb && wdata_i[TB_EN_BIT] && !q.en);
        reload_o  = hit_as ? wdata_i[AS_W-1:0] : q.stop_cnt;
        wr_any_o  = hit_tb || hit_prd || hit_on || hit_as;
    end

    always_comb begin
        rdata_o = '0;
        unique case (slot)
            SLOT_TBASE: begin
                rdata_o[SEL_W-1:0]  = q.sel;
                rdata_o[TB_EN_BIT]   = q.en;
                rdata_o[TB_AUTO_BIT] = q.auto_en;
                rdata_o[TB_MASK_BIT] = q.mask;
                rdata_o[TB_DONE_BIT] = q.done;
            end
            SLOT_PERIOD:  rdata_o[PRD_W-1:0] = q.period;
            SLOT_ONTIME:  rdata_o[PRD_W-1:0] = q.ontime;
            SLOT_STOPCNT: rdata_o[AS_W-1:0]  = q.stop_cnt;
            default:      rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign sel_o    = q.sel;
    assign en_o     = q.en;
    assign auto_o   = q.auto_en;
    assign mask_o   = q.mask;
    assign done_o   = q.done;
    assign period_o = q.period;
    assign ontime_o = q.ontime;

    // The done flag only ever rises because of a stop event
    p_done_from_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q.done) |-> $past(stop_i));
    // A stop without a concurrent control write turns the block off
    p_stop_disables_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_i && !hit_tb) |=> !q.en);
    // A control write clears the flag unless a stop lands with it
    p_done_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_tb && !stop_i) |=> !q.done);
    // Coincident stop and control write: written enable survives, flag set
    p_coincide_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_tb && stop_i && wdata_i[TB_EN_BIT]) |=> (q.en && q.done));
endmodule

// File: rtl/blink_prescale.sv
module blink_prescale #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 13
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int PRE_W = (MAX_SEL < 1) ? 1 : MAX_SEL;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_t;

    pre_t             q, d;
    logic [SEL_W-1:0] sel_eff;
    logic [PRE_W-1:0] low_mask;

    always_comb begin
        sel_eff = (int'(sel_i) > MAX_SEL) ? SEL_W'(MAX_SEL) : sel_i;
        for (int i = 0; i < PRE_W; i++) begin
            low_mask[i] = (i < int'(sel_eff));
        end
        tick_o = run_i && ((q.pre & low_mask) == low_mask);

        d = q;
        if (clear_i || !run_i) d.pre = '0;
        else                   d.pre = q.pre + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // With a divider above 1, two ticks never fall in adjacent cycles
    p_tick_spacing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && (sel_i != '0) && !clear_i) |=> !tick_o);
    // No tick while stopped
    p_no_tick_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |-> !tick_o);
endmodule

// File: rtl/blink_wave.sv
module blink_wave #(
    parameter int PRD_W = 12,
    parameter int AS_W  = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             auto_i,
    input  logic             tick_i,
    input  logic             restart_i,
    input  logic [AS_W-1:0]  reload_i,
    input  logic [PRD_W-1:0] period_i,
    input  logic [PRD_W-1:0] ontime_i,
    output logic             led_o,
    output logic             stop_o
);
    typedef struct packed {
        logic [PRD_W-1:0] cnt;
        logic [AS_W-1:0]  left;
    } wave_t;

    wave_t          q, d;
    logic [PRD_W:0] nxt;
    logic           wrap;

    always_comb begin
        nxt    = {1'b0, q.cnt} + 1'b1;
        wrap   = (nxt >= {1'b0, period_i});
        stop_o = run_i && auto_i && tick_i && wrap && !restart_i
                 && (q.left <= AS_W'(1));

        d = q;
        if (restart_i) begin
            d.cnt  = '0;
            d.left = reload_i;
        end else if (!run_i) begin
            d.cnt = '0;
        end else if (tick_i) begin
            if (wrap) begin
                d.cnt = '0;
                if (auto_i && (q.left != '0)) d.left = q.left - 1'b1;
            end else begin
                d.cnt = nxt[PRD_W-1:0];
            end
        end

        led_o = run_i && (q.cnt < ontime_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // Counter stays inside the programmed period
    p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_i != '0) |-> (q.cnt < period_i));
    // A restart puts the counter back to zero
    p_restart_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (q.cnt == '0));
    // Stopped block keeps its counter at zero
    p_idle_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !restart_i) |=> (q.cnt == '0));
endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
    parameter int SEL_W   = 4,
    parameter int MAX_SEL = 13,
    parameter int PRD_W   = 12,
    parameter int AS_W    = 16,
    parameter int DATA_W  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [3:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              led_o,
    output logic              irq_o
);
    logic [SEL_W-1:0] sel;
    logic             en, auto_en, mask, done, restart, wr_any, tick, stop;
    logic [PRD_W-1:0] period, ontime;
    logic [AS_W-1:0]  reload;
    logic             tb_write;

    blink_regs #(
        .SEL_W(SEL_W), .PRD_W(PRD_W), .AS_W(AS_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .stop_i    (stop),
        .rdata_o   (rdata_o),
        .sel_o     (sel),
        .en_o      (en),
        .auto_o    (auto_en),
        .mask_o    (mask),
        .done_o    (done),
        .period_o  (period),
        .ontime_o  (ontime),
        .restart_o (restart),
        .reload_o  (reload),
        .wr_any_o  (wr_any)
    );

    blink_prescale #(
        .SEL_W(SEL_W), .MAX_SEL(MAX_SEL)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (en),
        .clear_i (wr_any),
        .sel_i   (sel),
        .tick_o  (tick)
    );

    blink_wave #(
        .PRD_W(PRD_W), .AS_W(AS_W)
    ) u_wave (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (en),
        .auto_i    (auto_en),
        .tick_i    (tick),
        .restart_i (restart),
        .reload_i  (reload),
        .period_i  (period),
        .ontime_i  (ontime),
        .led_o     (led_o),
        .stop_o    (stop)
    );

    assign irq_o    = done && !mask;
    assign tb_write = wr_en_i && (addr_i == 4'h0);

    // After a stop that software does not override, the LED goes dark
    p_stop_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop && !tb_write) |=> !led_o);
    // The interrupt line never rises without a prior stop or mask change
    p_irq_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> ($past(stop) || $past(tb_write)));
endmodule

// File: tb/blink_gen_test.sv
module blink_gen_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        led, irq;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    blink_gen uut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .led_o(led), .irq_o(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic count_high(input int cycles, output int highs);
        highs = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (led) highs++;
        end
    endtask

    task automatic t_reset;
        logic [15:0] v;
        chk("R1", "led after reset", led, 0);
        chk("R1", "irq after reset", irq, 0);
        for (int a = 0; a < 16; a += 4) begin
            rd(4'(a), v);
            chk("R1", "register after reset", v, 0);
        end
    endtask

    task automatic t_regmap;
        logic [15:0] v;
        wr(4'h4, 16'hFFFF); rd(4'h4, v); chk("R2", "period width", v, 16'h0FFF);
        wr(4'h8, 16'hABCD); rd(4'h8, v); chk("R2", "on-time width", v, 16'h0BCD);
        wr(4'hC, 16'hBEEF); rd(4'hC, v); chk("R2", "autostop count", v, 16'hBEEF);
        wr(4'h0, 16'h00FF); rd(4'h0, v); chk("R2", "control, done bit read-only", v, 16'h007F);
        wr(4'h0, 16'h0000); rd(4'h0, v); chk("R2", "control cleared", v, 16'h0000);
        wr(4'h5, 16'h0123); rd(4'h4, v); chk("R2", "unaligned write ignored", v, 16'h0FFF);
    endtask

    task automatic t_basic;
        int h;
        wr(4'h4, 16'd4); wr(4'h8, 16'd1); wr(4'h0, 16'h0010);
        count_high(16, h); chk("R4", "period 4 on 1 highs/16", h, 4);
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'd5); wr(4'h8, 16'd3); wr(4'h0, 16'h0010);
        count_high(20, h); chk("R4", "period 5 on 3 highs/20", h, 12);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_edges;
        int h;
        wr(4'h4, 16'd4); wr(4'h8, 16'd0); wr(4'h0, 16'h0010);
        count_high(16, h); chk("R5", "on-time 0 stays low", h, 0);
        wr(4'h8, 16'd6);
        count_high(16, h); chk("R5", "on-time above period stays high", h, 16);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_divider;
        wr(4'h4, 16'd4); wr(4'h8, 16'd1); wr(4'h0, 16'h0012);
        repeat (4) @(negedge clk);
        chk("R3", "n=2 high through cycle 3", led, 1);
        @(negedge clk);
        chk("R3", "n=2 low at cycle 4", led, 0);
        wr(4'h0, 16'h0000);
        wr(4'h4, 16'd2); wr(4'h0, 16'h001F);
        repeat (8192) @(negedge clk);
        chk("R3", "n=15 clamps, high at cycle 8191", led, 1);
        @(negedge clk);
        chk("R3", "n=15 clamps to 13, low at cycle 8192", led, 0);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_autostop;
        int h; logic [15:0] v;
        wr(4'h4, 16'd4); wr(4'h8, 16'd2); wr(4'hC, 16'd3); wr(4'h0, 16'h0030);
        count_high(40, h); chk("R6", "highs before autostop", h, 6);
        chk("R6", "led low after stop", led, 0);
        chk("R7", "irq raised unmasked", irq, 1);
        rd(4'h0, v); chk("R6", "enable cleared, done set", v, 16'h00A0);
        wr(4'h0, 16'h0070);
        count_high(40, h); chk("R6", "masked run highs", h, 6);
        chk("R7", "irq masked", irq, 0);
        rd(4'h0, v); chk("R7", "done set while masked", v, 16'h00E0);
        wr(4'h0, 16'h0000);
        rd(4'h0, v); chk("R7", "control write clears done", v, 16'h0000);
        chk("R7", "irq low after clear", irq, 0);
        wr(4'hC, 16'd0); wr(4'h0, 16'h0030);
        count_high(24, h); chk("R6", "count 0 acts as 1", h, 2);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_restart;
        wr(4'h4, 16'd8); wr(4'h8, 16'd1); wr(4'h0, 16'h0010);
        repeat (3) @(negedge clk);
        chk("R8", "low mid period", led, 0);
        wr(4'h4, 16'd8);
        @(negedge clk);
        chk("R8", "period write restarts at 0", led, 1);
        @(negedge clk);
        chk("R8", "counter moves on after restart", led, 0);
        wr(4'hC, 16'd5);
        @(negedge clk);
        chk("R8", "autostop write restarts at 0", led, 1);
    endtask

    task automatic t_disable;
        int h;
        wr(4'h8, 16'd8);
        wr(4'h0, 16'h0000);
        count_high(16, h); chk("R10", "disabled stays low", h, 0);
        wr(4'h8, 16'd1);
        wr(4'h0, 16'h0010);
        @(negedge clk);
        chk("R10", "re-enable starts from counter 0", led, 1);
        wr(4'h0, 16'h0000);
    endtask

    task automatic t_coincide;
        int h; logic [15:0] v;
        wr(4'h4, 16'd4); wr(4'h8, 16'd2); wr(4'hC, 16'd3); wr(4'h0, 16'h0030);
        repeat (11) @(posedge clk);
        wr(4'h0, 16'h0010);
        count_high(8, h); chk("R9", "blinking continues after coincident write", h, 4);
        chk("R9", "irq raised by coincident stop", irq, 1);
        rd(4'h0, v); chk("R9", "enable kept and done set", v, 16'h0090);
        wr(4'h0, 16'h0000);
    endtask

    initial begin
        #(200000 * 20);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_basic();
        t_edges();
        t_divider();
        t_autostop();
        t_restart();
        t_disable();
        t_coincide();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule